// File: doc/BRIEF.md
# Multiplexed BCD Clock With Hourly Chime

This block keeps 24-hour time as three pairs of BCD digits and shows it on six common-anode seven-segment digits, one digit at a time. A single fast system clock drives everything. Counters inside the block divide it down to make a one-second strobe, a display-scan strobe and two square-wave chime tones. Every register runs on that one clock and advances only when its enable strobe is high.

Two buttons adjust the time. They arrive already debounced, as single-cycle pulses. The hour button steps the hours and the minute button steps the minutes. Near the end of every hour a speaker line beeps on the even seconds at a low pitch. At the final second it sounds at a higher pitch. At all other times it rests high.

Top module: `bcd_clock_chime`

## Requirements
- R1: Raising `clr` at once, with no clock edge needed, sets the time to 00:00:00, sets the scan to the first digit (`digitSel` = 011111) and resets all dividers and tone phases.
- R2: The seconds advance once every `TICK_CYCLES` clock cycles. The first advance happens on the `TICK_CYCLES`-th rising edge after `clr` falls. The seconds units count 0 to 9 and then carry into the tens, and 59 wraps to 00.
- R3: When the seconds wrap from 59, the minutes advance by one. When that step takes the minutes from 59 to 00, the hours advance by one.
- R4: The hours never exceed 23, and an hour step from 23 gives 00.
- R5: A one-cycle `hourAdv` pulse steps the hours and leaves the minutes and seconds alone. A one-cycle `minAdv` pulse steps the minutes, wrapping 59 to 00, and never changes the hours or seconds.
- R6: If an adjust pulse falls in the same cycle as a carry into the same counter, that counter moves by exactly one step. The seconds carry into the hours still applies when the minutes wrap.
- R7: The scan index advances once every `SCAN_CYCLES` cycles through 0 to 5 and then returns to 0. Index k drives select bit 5-k low and all other select bits high. The digits shown are, in order, hours tens, hours units, minutes tens, minutes units, seconds tens and seconds units.
- R8: `seg` is active-low with bit 7 (the decimal point) held high. The digits 0 to 9 map to C0, F9, A4, B0, 99, 92, 82, F8, 80 and 90 (hex).
- R9: `speaker` is 1 whenever the minutes are not 59 or the seconds are below 50. It is also 1 on seconds 51, 53, 55 and 57 of minute 59.
- R10: At minute 59 and seconds 50, 52, 54, 56 or 58, `speaker` follows the low tone. The low tone is a square wave that starts at 0 after clear and toggles once every `LO_HALF` cycles.
- R11: At 59:59 (minutes:seconds), `speaker` follows the high tone. The high tone is a square wave that starts at 0 after clear and toggles once every `HI_HALF` cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| clr | input | 1 | Asynchronous active-high clear |
| hourAdv | input | 1 | Debounced single-cycle hour step |
| minAdv | input | 1 | Debounced single-cycle minute step |
| seg | output | 8 | Active-low segments, bit 7 decimal point |
| digitSel | output | 6 | Active-low digit select, bit 5 = hours tens |
| speaker | output | 1 | Chime output, idles high |

## Verification
An adjust pulse can fall in the same cycle as the carry it duplicates. A minute pulse can arrive in the very cycle the seconds wrap from 59, and an hour pulse can arrive when that wrap also takes the minutes past 59. The bench tracks its own tick counter to find that exact cycle and drives both pulses in it. It then expects one step of the minutes and one step of the hours, not two. The displayed digits and the chime phase are compared on every cycle against a bench model, both in directed runs across 23:59:59 and under random pulse traffic.

// File: rtl/bcd_clock_pkg.sv
package bcd_clock_pkg;

  typedef struct packed {
    logic [3:0] tens;
    logic [3:0] units;
  } bcdPair_t;

  typedef struct packed {
    logic secTick;
    logic scanStep;
    logic loWave;
    logic hiWave;
  } ctrlStrobes_t;

  localparam int NUM_DIGITS = 6;

  // Next value of a BCD pair; wraps to 00 after topTens:topUnits.
  function automatic bcdPair_t bcdStep(bcdPair_t v, logic [3:0] topTens, logic [3:0] topUnits);
    bcdPair_t n;
    if (v.tens == topTens && v.units == topUnits) begin
      n = '0;
    end else if (v.units == 4'd9) begin
      n.tens  = v.tens + 4'd1;
      n.units = 4'd0;
    end else begin
      n.tens  = v.tens;
      n.units = v.units + 4'd1;
    end
    return n;
  endfunction

  // Active-low segment pattern, decimal point off; non-decimal input is blank.
  function automatic logic [7:0] segEncode(logic [3:0] d);
    case (d)
      4'd0: segEncode = 8'hC0;
      4'd1: segEncode = 8'hF9;
      4'd2: segEncode = 8'hA4;
      4'd3: segEncode = 8'hB0;
      4'd4: segEncode = 8'h99;
      4'd5: segEncode = 8'h92;
      4'd6: segEncode = 8'h82;
      4'd7: segEncode = 8'hF8;
      4'd8: segEncode = 8'h80;
      4'd9: segEncode = 8'h90;
      default: segEncode = 8'hFF;
    endcase
  endfunction

endpackage

// File: rtl/strobe_div.sv
module strobe_div #(
  parameter int DIV = 4
) (
  input  logic clk,
  input  logic clr,
  output logic strobe
);
  localparam int W = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [W-1:0] LAST = W'(DIV - 1);

  logic [W-1:0] cnt;

  always_ff @(posedge clk or posedge clr) begin
    if (clr) cnt <= '0;
    else if (cnt == LAST) cnt <= '0;
    else cnt <= cnt + 1'b1;
  end

  assign strobe = (cnt == LAST);
endmodule

// File: rtl/clock_ctrl.sv
module clock_ctrl
  import bcd_clock_pkg::*;
#(
  parameter int TICK_CYCLES = 50_000_000,
  parameter int SCAN_CYCLES = 100_000,
  parameter int LO_HALF     = 48_828,
  parameter int HI_HALF     = 24_414
) (
  input  logic         clk,
  input  logic         clr,
  output ctrlStrobes_t strobes
);
  localparam int NUM_DIV = 4;
  localparam int DIVS [NUM_DIV] = '{TICK_CYCLES, SCAN_CYCLES, LO_HALF, HI_HALF};

  logic [NUM_DIV-1:0] divHit;
  logic loWave, hiWave;

  for (genvar g = 0; g < NUM_DIV; g++) begin : g_div
    strobe_div #(.DIV(DIVS[g])) u_div (
      .clk(clk), .clr(clr), .strobe(divHit[g])
    );
  end

  always_ff @(posedge clk or posedge clr) begin
    if (clr) begin
      loWave <= 1'b0;
      hiWave <= 1'b0;
    end else begin
      if (divHit[2]) loWave <= ~loWave;
      if (divHit[3]) hiWave <= ~hiWave;
    end
  end

  assign strobes.secTick  = divHit[0];
  assign strobes.scanStep = divHit[1];
  assign strobes.loWave   = loWave;
  assign strobes.hiWave   = hiWave;
endmodule

// File: rtl/clock_datapath.sv
module clock_datapath
  import bcd_clock_pkg::*;
(
  input  logic         clk,
  input  logic         clr,
  input  ctrlStrobes_t strobes,
  input  logic         hourAdv,
  input  logic         minAdv,
  output bcdPair_t     secNow,
  output bcdPair_t     minNow,
  output bcdPair_t     hrNow,
  output logic [7:0]   seg,
  output logic [NUM_DIGITS-1:0] digitSel,
  output logic         speaker
);
  localparam logic [2:0] LAST_IDX = 3'(NUM_DIGITS - 1);

  logic [2:0] scanIdx;
  logic secCarry, minWrap, hourStep;
  logic [3:0] digitVal [NUM_DIGITS];
  logic [3:0] shownDigit;
  logic inWindow;

  assign secCarry = strobes.secTick && secNow == 8'h59;
  assign minWrap  = secCarry && minNow == 8'h59;
  assign hourStep = hourAdv || minWrap;

  always_ff @(posedge clk or posedge clr) begin
    if (clr) begin
      secNow  <= '0;
      minNow  <= '0;
      hrNow   <= '0;
      scanIdx <= '0;
    end else begin
      if (strobes.secTick) secNow <= bcdStep(secNow, 4'd5, 4'd9);
      if (secCarry || minAdv) minNow <= bcdStep(minNow, 4'd5, 4'd9);
      if (hourStep) hrNow <= bcdStep(hrNow, 4'd2, 4'd3);
      if (strobes.scanStep) scanIdx <= (scanIdx == LAST_IDX) ? 3'd0 : scanIdx + 3'd1;
    end
  end

  always_comb begin
    digitVal[0] = hrNow.tens;
    digitVal[1] = hrNow.units;
    digitVal[2] = minNow.tens;
    digitVal[3] = minNow.units;
    digitVal[4] = secNow.tens;
    digitVal[5] = secNow.units;
    shownDigit  = 4'hF;
    for (int i = 0; i < NUM_DIGITS; i++)
      if (scanIdx == 3'(i)) shownDigit = digitVal[i];
  end

  for (genvar d = 0; d < NUM_DIGITS; d++) begin : g_sel
    assign digitSel[NUM_DIGITS-1-d] = (scanIdx != 3'(d));
  end

  assign seg = segEncode(shownDigit);

  assign inWindow = (minNow == 8'h59) && (secNow.tens == 4'd5);

  always_comb begin
    if (!inWindow)                  speaker = 1'b1;
    else if (secNow.units == 4'd9)  speaker = strobes.hiWave;
    else if (!secNow.units[0])      speaker = strobes.loWave;
    else                            speaker = 1'b1;
  end
endmodule

// File: rtl/bcd_clock_chime.sv
module bcd_clock_chime
  import bcd_clock_pkg::*;
#(
  parameter int TICK_CYCLES = 50_000_000,
  parameter int SCAN_CYCLES = 100_000,
  parameter int LO_HALF     = 48_828,
  parameter int HI_HALF     = 24_414
) (
  input  logic       clk,
  input  logic       clr,
  input  logic       hourAdv,
  input  logic       minAdv,
  output logic [7:0] seg,
  output logic [5:0] digitSel,
  output logic       speaker
);
  ctrlStrobes_t strobes;
  bcdPair_t secNow, minNow, hrNow;

  clock_ctrl #(
    .TICK_CYCLES(TICK_CYCLES), .SCAN_CYCLES(SCAN_CYCLES),
    .LO_HALF(LO_HALF), .HI_HALF(HI_HALF)
  ) u_ctrl (
    .clk(clk), .clr(clr), .strobes(strobes)
  );

  clock_datapath u_dp (
    .clk(clk), .clr(clr), .strobes(strobes),
    .hourAdv(hourAdv), .minAdv(minAdv),
    .secNow(secNow), .minNow(minNow), .hrNow(hrNow),
    .seg(seg), .digitSel(digitSel), .speaker(speaker)
  );
endmodule

// File: rtl/bcd_clock_chime_chk.sv
module bcd_clock_chime_chk
  import bcd_clock_pkg::*;
(
  input logic       clk,
  input logic       clr,
  input logic       minAdv,
  input logic       secTick,
  input bcdPair_t   secNow,
  input bcdPair_t   minNow,
  input bcdPair_t   hrNow,
  input logic [7:0] seg,
  input logic [5:0] digitSel,
  input logic       speaker
);
  // R7
  sel_one_low_chk: assert property (@(posedge clk) disable iff (clr)
    $countones(~digitSel) == 1);

  // R7
  sel_order_chk: assert property (@(posedge clk) disable iff (clr)
    (digitSel != $past(digitSel)) |->
      (((~digitSel) == ((~$past(digitSel)) >> 1)) ||
       (digitSel == 6'b011111 && $past(digitSel) == 6'b111110)));

  // R8
  seg_dp_off_chk: assert property (@(posedge clk) disable iff (clr) seg[7]);

  // R4
  hour_range_chk: assert property (@(posedge clk) disable iff (clr)
    (hrNow.tens < 4'd2) || (hrNow.tens == 4'd2 && hrNow.units <= 4'd3));

  // R2
  sec_on_tick_chk: assert property (@(posedge clk) disable iff (clr)
    (secNow != $past(secNow)) |-> $past(secTick));

  // R9
  spk_idle_chk: assert property (@(posedge clk) disable iff (clr)
    !(minNow == 8'h59 && secNow.tens == 4'd5) |-> speaker);

  // R5
  min_adv_sec_chk: assert property (@(posedge clk) disable iff (clr)
    (minAdv && !secTick) |=> $stable(secNow));
endmodule

bind bcd_clock_chime bcd_clock_chime_chk u_chk (
  .clk(clk), .clr(clr), .minAdv(minAdv), .secTick(strobes.secTick),
  .secNow(secNow), .minNow(minNow), .hrNow(hrNow),
  .seg(seg), .digitSel(digitSel), .speaker(speaker)
);

// File: tb/bcd_clock_chime_test.sv
module bcd_clock_chime_test;
  localparam int CLK_PERIOD = 10;
  localparam int TICK = 40;
  localparam int SCAN = 2;
  localparam int LOH  = 5;
  localparam int HIH  = 2;

  logic clk = 1'b0;
  logic clr, hourAdv, minAdv;
  logic [7:0] seg;
  logic [5:0] digitSel;
  logic speaker;

  int checks = 0, fails = 0;
  bit finished = 0;
  string phase = "R1";

  int hh, mm, ss, tc, sc, lc, hc, idx;
  bit loW, hiW;

  always #(CLK_PERIOD/2) clk = ~clk;

  bcd_clock_chime #(.TICK_CYCLES(TICK), .SCAN_CYCLES(SCAN), .LO_HALF(LOH), .HI_HALF(HIH)) uut (
    .clk(clk), .clr(clr), .hourAdv(hourAdv), .minAdv(minAdv),
    .seg(seg), .digitSel(digitSel), .speaker(speaker)
  );

  function automatic logic [7:0] expSeg(int d);
    case (d)
      0: return 8'hC0; 1: return 8'hF9; 2: return 8'hA4; 3: return 8'hB0;
      4: return 8'h99; 5: return 8'h92; 6: return 8'h82; 7: return 8'hF8;
      8: return 8'h80; 9: return 8'h90; default: return 8'hFF;
    endcase
  endfunction

  function automatic int shownDigit(int i, int h, int m, int s);
    case (i)
      0: return h / 10; 1: return h % 10; 2: return m / 10;
      3: return m % 10; 4: return s / 10; default: return s % 10;
    endcase
  endfunction

  task automatic check(string tag, int act, int exp, string what);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h at %0t", tag, what, act, exp, $time);
    end
  endtask

  task automatic modelReset();
    hh = 0; mm = 0; ss = 0; tc = 0; sc = 0; lc = 0; hc = 0; idx = 0; loW = 0; hiW = 0;
  endtask

  task automatic modelStep();
    bit secTick, secCarry, hrStep;
    if (clr) begin modelReset(); return; end
    secTick  = (tc == TICK-1);
    secCarry = secTick && ss == 59;
    hrStep   = hourAdv || (secCarry && mm == 59);
    if (sc == SCAN-1) idx = (idx == 5) ? 0 : idx + 1;
    if (lc == LOH-1) loW = !loW;
    if (hc == HIH-1) hiW = !hiW;
    tc = (tc + 1) % TICK; sc = (sc + 1) % SCAN; lc = (lc + 1) % LOH; hc = (hc + 1) % HIH;
    if (secTick) ss = (ss + 1) % 60;
    if (secCarry || minAdv) mm = (mm + 1) % 60;
    if (hrStep) hh = (hh + 1) % 24;
  endtask

  task automatic compareAll();
    int expSpk;
    string spkTag;
    check(phase, seg, expSeg(shownDigit(idx, hh, mm, ss)), "seg");
    check("R7", digitSel, ~(6'b100000 >> idx) & 6'h3F, "digitSel");
    if (mm == 59 && ss == 59) begin expSpk = hiW; spkTag = "R11"; end
    else if (mm == 59 && ss >= 50 && ss % 2 == 0) begin expSpk = loW; spkTag = "R10"; end
    else begin expSpk = 1; spkTag = "R9"; end
    check(spkTag, speaker, expSpk, "speaker");
  endtask

  task automatic cycle();
    @(posedge clk);
    modelStep();
    @(negedge clk);
    compareAll();
  endtask

  task automatic pulseHour();
    hourAdv = 1; cycle(); hourAdv = 0; cycle();
  endtask

  task automatic pulseMin();
    minAdv = 1; cycle(); minAdv = 0; cycle();
  endtask

  initial begin
    int r;
    r = $urandom(32'd1357);
    clr = 1; hourAdv = 0; minAdv = 0;
    modelReset();
    @(negedge clk);
    // R1: reset state
    check("R1", digitSel, 6'b011111, "digitSel reset");
    check("R1", seg, 8'hC0, "seg reset");
    check("R1", speaker, 1, "speaker reset");
    repeat (2) cycle();
    clr = 0;

    // R2 R3 R8: free run past a minute carry
    phase = "R2,R3,R8";
    repeat (70 * TICK) cycle();

    // R1: asynchronous clear between edges
    clr = 1;
    #(CLK_PERIOD/4);
    modelReset();
    check("R1", digitSel, 6'b011111, "digitSel async clear");
    check("R1", seg, 8'hC0, "seg async clear");
    check("R1", speaker, 1, "speaker async clear");
    @(negedge clk);
    cycle();
    clr = 0;

    // R5 R4: adjust pulses, hours wrap through 23
    phase = "R4,R5";
    repeat (7) pulseMin();
    repeat (26) pulseHour();

    // R9 R10 R11 R4: chime window and 23:59:59 rollover
    phase = "R4,R9,R10,R11";
    while (hh != 23) pulseHour();
    while (mm != 59) pulseMin();
    repeat (65 * TICK) cycle();

    // R6: both adjust pulses in the cycle of the seconds wrap at minute 59
    phase = "R6";
    while (mm != 59) pulseMin();
    while (!(ss == 59 && tc == TICK-1)) cycle();
    minAdv = 1; hourAdv = 1;
    cycle();
    minAdv = 0; hourAdv = 0;
    repeat (20 * TICK) cycle();

    // R3 R5: random pulse traffic
    phase = "R3,R5";
    for (int k = 0; k < 3000; k++) begin
      r = $urandom % 100;
      hourAdv = (r < 3);
      minAdv  = (r >= 3 && r < 6);
      cycle();
    end
    hourAdv = 0; minAdv = 0;
    cycle();

    finished = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      checks++; fails++;
      $display("FAIL watchdog R1 actual=timeout expected=done");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule